// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block turns per-descriptor completion strobes from a receive-done queue and a transmit-done queue into a single interrupt line, so that software is not interrupted once per descriptor. Each queue keeps a count of descriptors that have arrived but not yet been reported. An arrival event is raised when that count reaches a programmable batch size. A separate timeout event is raised when the oldest unreported descriptor has waited a programmable number of clock cycles. Either event sets a sticky bit in a raw status word and clears the queue's pending count.

Software reads and clears the raw status through a small register port with write-one-to-clear semantics. An enable word selects which raw bits may drive the interrupt line. A masked-status view shows the raw bits AND the enable word. The queue pointer logic outside this block supplies one arrival strobe per completed descriptor.

Register map (word index on `wr_addr`/`rd_addr`): 0 raw status (write 1 to clear), 1 enable, 2 masked status (read-only), 3 batch sizes, 4 receive timeout, 5 transmit timeout. Any other index reads 0 and ignores writes.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset the raw status, the enable word and both timeouts read 0, the batch-size register reads 0x00010001, and `irq` is low.
- R2: Writing the raw status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: The masked-status register (index 2) reads raw status AND enable, and writes to it have no effect.
- R4: `irq` is high exactly when at least one bit of raw status AND enable is 1.
- R5: The receive batch size sits in bits [15:0] of register 3. When the receive pending count reaches it, raw bit 17 is set at that strobe's capturing edge and the pending count returns to 0.
- R6: The transmit batch size sits in bits [31:16] of register 3. When the transmit pending count reaches it, raw bit 19 is set and the transmit pending count returns to 0.
- R7: A batch size of 0 or 1 sets the arrival bit on every strobe.
- R8: With a nonzero timeout T (register 4 for receive, 5 for transmit), the timeout bit (28 for receive, 29 for transmit) is set at the T-th clock edge after the edge that captured the first pending strobe, unless the batch fires first. The pending count is then cleared, including any strobe captured at that edge.
- R9: A timeout value of 0 disables that queue's timeout bit. Pending descriptors wait until the batch size is reached.
- R10: The age timer restarts from zero whenever the pending count is cleared. Further strobes do not restart it. An arrival event and a timeout event never fire together for one queue.
- R11: If a hardware event and a write-one-to-clear hit the same raw bit in the same cycle, the bit ends set.
- R12: Enable, batch-size and timeout registers read back as written. Raw bits other than 17, 19, 28 and 29 always read 0. Unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done_strb | input | 1 | One pulse per completed receive descriptor |
| tx_done_strb | input | 1 | One pulse per completed transmit descriptor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register index for the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Combined interrupt line |

## Verification
A strobe or write on the input side takes effect at the next rising edge. Raw status, masked status and `irq` reflect it from that edge on, one register stage in all. A timeout bit lands exactly T edges after the edge that captured the first pending strobe, so the directed checks probe both the cycle before and the cycle of that edge. Inputs change 1 ns after a rising edge. Directed reads settle half a nanosecond later, and a behavioural model updated on the rising edge is compared against `rd_data` and `irq` at every falling edge.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NQ      = 2;
    localparam int Q_RX    = 0;
    localparam int Q_TX    = 1;

    // status bit positions and batch-size field placement
    localparam int RX_IN_BIT   = 17;
    localparam int TX_IN_BIT   = 19;
    localparam int RX_TMO_BIT  = 28;
    localparam int TX_TMO_BIT  = 29;
    localparam int TX_CTH_LSB  = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_RAW  = 3'd0,
        A_EN   = 3'd1,
        A_MSK  = 3'd2,
        A_CTH  = 3'd3,
        A_RTMO = 3'd4,
        A_TTMO = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic cnt_hit;
        logic tmo_hit;
    } q_evt_t;

    localparam logic [DATA_W-1:0] CTH_RESET = 32'h0001_0001;

    function automatic int in_bit(input int q);
        return (q == Q_RX) ? RX_IN_BIT : TX_IN_BIT;
    endfunction

    function automatic int tmo_bit(input int q);
        return (q == Q_RX) ? RX_TMO_BIT : TX_TMO_BIT;
    endfunction

    function automatic int cth_lsb(input int q);
        return (q == Q_RX) ? 0 : TX_CTH_LSB;
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int q = 0; q < NQ; q++) begin
            m[in_bit(q)]  = 1'b1;
            m[tmo_bit(q)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cic_queue_ctr.sv
module cic_queue_ctr
    import cic_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arrive,
    input  logic [CNT_W-1:0] cnt_th,
    input  logic [TMO_W-1:0] tmo_th,
    output q_evt_t           evt
);

    logic [CNT_W-1:0] pend_q;
    logic [TMO_W-1:0] age_q;
    logic [CNT_W:0]   pend_inc;
    logic [TMO_W:0]   age_inc;
    logic             waiting;

    always_comb begin
        pend_inc    = {1'b0, pend_q} + 1'b1;
        age_inc     = {1'b0, age_q} + 1'b1;
        waiting     = (pend_q != '0);
        evt.cnt_hit = arrive && (pend_inc >= {1'b0, cnt_th});
        evt.tmo_hit = !evt.cnt_hit && waiting && (tmo_th != '0)
                      && (age_inc >= {1'b0, tmo_th});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            age_q  <= '0;
        end else if (evt.cnt_hit || evt.tmo_hit) begin
            pend_q <= '0;
            age_q  <= '0;
        end else begin
            if (arrive) begin
                pend_q <= pend_inc[CNT_W-1:0];
            end
            age_q <= waiting ? age_inc[TMO_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/cic_cfg.sv
module cic_cfg
    import cic_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         cth_q,
    output logic [NQ-1:0][TMO_W-1:0]  tmo_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cth_q <= CTH_RESET;
            tmo_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CTH:   cth_q       <= wr_data;
                A_RTMO:  tmo_q[Q_RX] <= wr_data[TMO_W-1:0];
                A_TTMO:  tmo_q[Q_TX] <= wr_data[TMO_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cic_status.sv
module cic_status
    import cic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] raw_q,
    output logic [DATA_W-1:0] en_q
);

    localparam logic [DATA_W-1:0] KEEP = impl_mask();

    logic [DATA_W-1:0] w1c;

    always_comb begin
        w1c = (wr_en && reg_addr_e'(wr_addr) == A_RAW) ? wr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            // hardware set is applied after the clear so it prevails
            raw_q <= ((raw_q & ~w1c) | set_vec) & KEEP;
            if (wr_en && reg_addr_e'(wr_addr) == A_EN) begin
                en_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
    import cic_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TMO_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_done_strb,
    input  logic              tx_done_strb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    logic [DATA_W-1:0]        raw_q;
    logic [DATA_W-1:0]        en_q;
    logic [DATA_W-1:0]        set_vec;
    logic [DATA_W-1:0]        cth_q;
    logic [NQ-1:0][TMO_W-1:0] tmo_q;
    logic [NQ-1:0]            arrive;
    q_evt_t                   evt [NQ];

    assign arrive[Q_RX] = rx_done_strb;
    assign arrive[Q_TX] = tx_done_strb;

    cic_cfg #(.TMO_W(TMO_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cth_q   (cth_q),
        .tmo_q   (tmo_q)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        localparam int LSB = cth_lsb(q);
        cic_queue_ctr #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .arrive (arrive[q]),
            .cnt_th (cth_q[LSB +: CNT_W]),
            .tmo_th (tmo_q[q]),
            .evt    (evt[q])
        );
    end

    always_comb begin
        set_vec = '0;
        for (int q = 0; q < NQ; q++) begin
            set_vec[in_bit(q)]  = evt[q].cnt_hit;
            set_vec[tmo_bit(q)] = evt[q].tmo_hit;
        end
    end

    cic_status u_status (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .set_vec (set_vec),
        .raw_q   (raw_q),
        .en_q    (en_q)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_RAW:   rd_data = raw_q;
            A_EN:    rd_data = en_q;
            A_MSK:   rd_data = raw_q & en_q;
            A_CTH:   rd_data = cth_q;
            A_RTMO:  rd_data = DATA_W'(tmo_q[Q_RX]);
            A_TTMO:  rd_data = DATA_W'(tmo_q[Q_TX]);
            default: rd_data = '0;
        endcase
    end

    assign irq = |(raw_q & en_q);

endmodule

// File: rtl/cic_checker.sv
module cic_checker
    import cic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] raw_q,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] set_vec,
    input logic              irq
);

    localparam logic [DATA_W-1:0] KEEP = impl_mask();

    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'(A_RAW) && set_vec == '0)
        |=> ((raw_q & $past(wr_data)) == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_addr == 3'(A_RAW)) && set_vec == '0)
        |=> $stable(raw_q));

    assert_irq_R4: assert property (@(posedge clk) disable iff (rst)
        irq == ((raw_q & en_q) != '0));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(set_vec[RX_IN_BIT] && set_vec[RX_TMO_BIT])
        && !(set_vec[TX_IN_BIT] && set_vec[TX_TMO_BIT]));

    assert_unused_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (raw_q & ~KEEP) == '0);

endmodule

bind cmpl_irq_coalescer cic_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .raw_q   (raw_q),
    .en_q    (en_q),
    .set_vec (set_vec),
    .irq     (irq)
);

// File: tb/sim_cmpl_irq_coalescer.sv
`timescale 1ns/1ps
module sim_cmpl_irq_coalescer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_s = 1'b0;
    logic        tx_s = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic [2:0]  rd_addr = 3'd0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cmpl_irq_coalescer u0 (
        .clk(clk), .rst(rst), .rx_done_strb(rx_s), .tx_done_strb(tx_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s at %0t: got=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [31:0] m_raw, m_en, m_cth;
    longint      m_tmo [2];
    longint      m_age [2];
    int          m_pend [2];

    always @(posedge clk) begin : model
        logic [31:0] setv, clr;
        longint th;
        bit arr, fire_c, fire_t, busy;
        if (rst) begin
            m_raw = 0; m_en = 0; m_cth = 32'h0001_0001;
            for (int q = 0; q < 2; q++) begin
                m_tmo[q] = 0; m_age[q] = 0; m_pend[q] = 0;
            end
        end else begin
            setv = 0;
            for (int q = 0; q < 2; q++) begin
                arr    = (q == 0) ? rx_s : tx_s;
                th     = (q == 0) ? longint'(m_cth[15:0]) : longint'(m_cth[31:16]);
                busy   = (m_pend[q] != 0);
                fire_c = arr && (m_pend[q] + 1 >= th);
                fire_t = !fire_c && busy && (m_tmo[q] != 0) && (m_age[q] + 1 >= m_tmo[q]);
                if (fire_c) setv[(q == 0) ? 17 : 19] = 1'b1;
                if (fire_t) setv[(q == 0) ? 28 : 29] = 1'b1;
                if (fire_c || fire_t) begin
                    m_pend[q] = 0; m_age[q] = 0;
                end else begin
                    if (arr) m_pend[q] = m_pend[q] + 1;
                    m_age[q] = busy ? m_age[q] + 1 : 0;
                end
            end
            clr = (wr_en && wr_addr == 3'd0) ? wr_data : 32'd0;
            m_raw = (m_raw & ~clr) | setv;
            if (wr_en) begin
                case (wr_addr)
                    3'd1: m_en = wr_data;
                    3'd3: m_cth = wr_data;
                    3'd4: m_tmo[0] = longint'(wr_data);
                    3'd5: m_tmo[1] = longint'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison on the falling edge
    always @(negedge clk) begin
        logic [31:0] e;
        string tag;
        if (!rst && !finished) begin
            case (rd_addr)
                3'd0: begin e = m_raw;         tag = "R2 raw";    end
                3'd1: begin e = m_en;          tag = "R12 enable"; end
                3'd2: begin e = m_raw & m_en;  tag = "R3 masked"; end
                3'd3: begin e = m_cth;         tag = "R12 batch"; end
                3'd4: begin e = m_tmo[0][31:0]; tag = "R12 rx_tmo"; end
                3'd5: begin e = m_tmo[1][31:0]; tag = "R12 tx_tmo"; end
                default: begin e = 0;          tag = "R12 unmapped"; end
            endcase
            chk(tag, rd_data, e);
            chk("R4 irq", {31'd0, irq}, {31'd0, |(m_raw & m_en)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic strb(input int q);
        if (q == 0) rx_s = 1'b1; else tx_s = 1'b1;
        step();
        rx_s = 1'b0; tx_s = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic raw_is(input string tag, input logic [31:0] exp);
        logic [31:0] v;
        peek(3'd0, v);
        chk(tag, v, exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        raw_is("R1 raw", 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        peek(3'd1, v); chk("R1 enable", v, 32'h0);
        peek(3'd3, v); chk("R1 batch", v, 32'h0001_0001);
        peek(3'd4, v); chk("R1 rx_tmo", v, 32'h0);
        peek(3'd5, v); chk("R1 tx_tmo", v, 32'h0);
        rd_addr = 3'd0;

        wr(3'd1, 32'hFFFF_FFFF);
        strb(0);
        raw_is("R7 default batch", 32'h0002_0000);
        chk("R4 irq high", {31'd0, irq}, 32'd1);
        wr(3'd0, 32'h0002_0000);
        raw_is("R2 cleared", 32'h0);

        // R5 / R6 batch sizes
        wr(3'd3, 32'h0002_0003);
        strb(0); strb(0);
        raw_is("R5 below batch", 32'h0);
        strb(0);
        raw_is("R5 batch reached", 32'h0002_0000);
        strb(1);
        raw_is("R6 below batch", 32'h0002_0000);
        strb(1);
        raw_is("R6 batch reached", 32'h000A_0000);
        wr(3'd0, 32'hFFFF_FFFF);
        raw_is("R2 clear all", 32'h0);

        // R3 masking
        wr(3'd1, 32'h0008_0000);
        strb(0); strb(0); strb(0);
        peek(3'd2, v); chk("R3 masked off", v, 32'h0);
        chk("R4 masked irq low", {31'd0, irq}, 32'd0);
        strb(1); strb(1);
        peek(3'd2, v); chk("R3 masked on", v, 32'h0008_0000);
        chk("R4 irq via tx", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'hFFFF_FFFF);
        peek(3'd1, v); chk("R3 masked write ignored", v, 32'h0008_0000);
        raw_is("R3 raw untouched", 32'h000A_0000);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);

        // R8 receive timeout of 10
        wr(3'd4, 32'd10);
        peek(3'd4, v); chk("R12 rx_tmo readback", v, 32'd10);
        rd_addr = 3'd0;
        strb(0);
        idle(9);
        raw_is("R8 rx one cycle early", 32'h0);
        idle(1);
        raw_is("R8 rx timeout", 32'h1000_0000);
        strb(0); strb(0);
        raw_is("R8 pending cleared", 32'h1000_0000);
        strb(0);
        raw_is("R10 batch after timeout", 32'h1002_0000);
        wr(3'd0, 32'hFFFF_FFFF);
        idle(15);
        raw_is("R10 timer restarted", 32'h0);

        // R9 timeout disabled
        wr(3'd4, 32'd0);
        strb(0);
        idle(40);
        raw_is("R9 no timeout", 32'h0);
        strb(0); strb(0);
        raw_is("R9 batch still works", 32'h0002_0000);
        wr(3'd0, 32'hFFFF_FFFF);

        // R8 transmit timeout of 5
        wr(3'd5, 32'd5);
        strb(1);
        idle(4);
        raw_is("R8 tx one cycle early", 32'h0);
        idle(1);
        raw_is("R8 tx timeout", 32'h2000_0000);
        wr(3'd0, 32'hFFFF_FFFF);

        // R7 batch size zero
        wr(3'd3, 32'h0);
        strb(1);
        raw_is("R7 zero batch tx", 32'h0008_0000);
        strb(0);
        raw_is("R7 zero batch rx", 32'h000A_0000);
        wr(3'd0, 32'hFFFF_FFFF);

        // R11 set versus clear
        wr(3'd3, 32'h0001_0001);
        strb(0);
        raw_is("R11 setup", 32'h0002_0000);
        rx_s = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0002_0000;
        step();
        rx_s = 1'b0; wr_en = 1'b0;
        raw_is("R11 set wins", 32'h0002_0000);
        wr(3'd0, 32'h0002_0000);
        raw_is("R11 later clear", 32'h0);

        // R12 readback and unmapped
        peek(3'd5, v); chk("R12 tx_tmo readback", v, 32'd5);
        peek(3'd3, v); chk("R12 batch readback", v, 32'h0001_0001);
        wr(3'd7, 32'hFFFF_FFFF);
        peek(3'd7, v); chk("R12 unmapped", v, 32'h0);
        peek(3'd1, v); chk("R12 enable readback", v, 32'hFFFF_FFFF);
        rd_addr = 3'd0;
        idle(3);

        finished = 1;
        summary();
        $finish;
    end

endmodule